// File: doc/BRIEF.md
# Edge-Interrupt GPIO Pin Controller

This block manages thirteen general-purpose pins through a byte-wide register bus. Each pin has two registers. The drive register sets the direction, the drive style, the pull resistor and the output level. The sense register returns the synchronized pin level and picks which transitions on that pin count as events. Pad electrics are not modelled. The block only drives output-enable, output-level, pull-enable and pull-select signals towards the pad ring.

Transitions that match a pin's sense mode latch a pending bit. The pending bits sit in two status bytes: pins 0 to 6 in the first byte and pins 7 to 12 in the second. Software clears a pending bit by writing a one to it. A companion mask byte for each group gates which pending bits reach the single registered interrupt line. If a new transition and a clear hit the same bit in the same cycle, the transition is kept.

A read is requested with the read strobe, and the data appears on the read-data port after the next clock edge. Writes take effect on the clock edge where the write strobe is high.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, all pads are released: pad_oe, pad_out and pull_en are 0 and irq is 0. Every drive and sense register reads 0, both status bytes read 0, and the mask bytes read 0x7F (pins 0-6) and 0x3F (pins 7-12).
- R2: The drive register of pin p is at 0x4E44+p. It holds six bits, which read back as written:
  - bit 5: direction (1 = output)
  - bit 4: drive style (1 = push-pull, 0 = open-drain)
  - bit 3: pull enable
  - bits 2:1: pull select
  - bit 0: output value
- R3: With direction 1 and push-pull drive, pad_oe is 1 and pad_out equals the value bit. With direction 0, pad_oe is 0. pad_out is 0 whenever pad_oe is 0.
- R4: With direction 1 and open-drain drive, a value of 1 releases the pad (pad_oe 0, pad_out 0). A value of 0 drives it low (pad_oe 1, pad_out 0).
- R5: pull_en[p] follows bit 3 and pull_sel[2p+1:2p] follows bits 2:1 of the drive register, whatever the direction.
- R6: The sense register of pin p is at 0x4E51+p.
  - Bit 0 reads the pin level after a two-flop synchronizer. Writes to bit 0 are ignored.
  - Bits 2:1 hold the event mode, which reads back as written.
- R7: The event modes are 0 = none, 1 = falling, 2 = rising and 3 = both. A pin transition that matches the mode sets that pin's pending bit. A transition that does not match sets nothing.
- R8: Pending bits for pins 0-6 are at 0x4E0B, bits 0-6. Pending bits for pins 7-12 are at 0x4E0C, bits 0-5. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R9: When a transition event and a write-one-to-clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: The mask bytes are at 0x4E19 (pins 0-6) and 0x4E1A (pins 7-12), and a mask bit of 1 blocks that pin. irq is a register that goes high one cycle after any unmasked pending bit exists, and goes low one cycle after none does.
- R11: Reads from unmapped addresses return 0. Bits above a group's width in its status and mask bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid after the edge that sampled bus_re |
| pin_in | input | 13 | Pin levels from the pads (asynchronous) |
| pad_oe | output | 13 | Per-pin output enable |
| pad_out | output | 13 | Per-pin driven level |
| pull_en | output | 13 | Per-pin pull resistor enable |
| pull_sel | output | 26 | Per-pin 2-bit pull select, pin p at bits 2p+1:2p |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that:
- an input-direction pin never drives its pad;
- an open-drain pin never drives high;
- a pending bit never appears without an event in the previous cycle;
- an event always lands in its pending bit, even against a clear;
- a cleared bit with no event stays clear;
- irq only rises after an unmasked pending bit.

Only the bench scenarios can show the rest:
- the address map;
- the read-back of each field;
- that each event mode reacts to exactly the right transition direction;
- the timing of the same-cycle clear collision, driven from the ports;
- the mask gating as software observes it.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   typedef enum logic [1:0] {
      DET_OFF  = 2'd0,
      DET_FALL = 2'd1,
      DET_RISE = 2'd2,
      DET_BOTH = 2'd3
   } det_mode_e;

   // drive register field positions
   localparam int OC_VAL  = 0;
   localparam int OC_PSEL = 1;
   localparam int OC_PEN  = 3;
   localparam int OC_DRV  = 4;
   localparam int OC_DIR  = 5;
   localparam int OC_W    = 6;

   function automatic logic edge_fires(det_mode_e m, logic rise, logic fall);
      case (m)
         DET_FALL: return fall;
         DET_RISE: return rise;
         DET_BOTH: return rise | fall;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_edge_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            octl_we,
   input  logic [OC_W-1:0] octl_wd,
   input  logic            ictl_we,
   input  logic [1:0]      mode_wd,
   input  logic            pin_in,
   output logic [OC_W-1:0] octl_q,
   output det_mode_e       mode_q,
   output logic            level_q,
   output logic            edge_evt,
   output logic            pad_oe,
   output logic            pad_out,
   output logic            pull_en,
   output logic [1:0]      pull_sel
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pin_cell: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise, fall;
   logic                   push_pull, dir_out, val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
         octl_q <= '0;
         mode_q <= DET_OFF;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
         prev_q <= sync_q[SYNC_STAGES-1];
         if (octl_we) octl_q <= octl_wd;
         if (ictl_we) mode_q <= det_mode_e'(mode_wd);
      end
   end

   assign level_q  = sync_q[SYNC_STAGES-1];
   assign rise     = level_q & ~prev_q;
   assign fall     = ~level_q & prev_q;
   assign edge_evt = edge_fires(mode_q, rise, fall);

   assign push_pull = octl_q[OC_DRV];
   assign dir_out   = octl_q[OC_DIR];
   assign val       = octl_q[OC_VAL];
   assign pad_oe    = dir_out & (push_pull | ~val);
   assign pad_out   = dir_out & push_pull & val;
   assign pull_en   = octl_q[OC_PEN];
   assign pull_sel  = octl_q[OC_PSEL +: 2];

   // R4
   od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !octl_q[OC_DRV] |-> !pad_out);

   // R3
   input_dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !octl_q[OC_DIR] |-> (!pad_oe && !pad_out));

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stat_we,
   input  logic         mask_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] evt,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] mask_q,
   output logic         pend
);

   logic [W-1:0] clr;

   assign clr = stat_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= (stat_q & ~clr) | evt;
         if (mask_we) mask_q <= wdata;
      end
   end

   assign pend = |(stat_q & ~mask_q);

   // R9
   evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

   // R8
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |=> ((stat_q & $past(wdata & ~evt)) == '0));

   // R7
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int                NUM_PINS    = 13,
   parameter int                GRP0_PINS   = 7,
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] OUT_BASE    = 'h4E44,
   parameter logic [ADDR_W-1:0] IN_BASE     = 'h4E51,
   parameter logic [ADDR_W-1:0] STAT_BASE   = 'h4E0B,
   parameter logic [ADDR_W-1:0] MASK_BASE   = 'h4E19
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_we,
   input  logic                  bus_re,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pull_en,
   output logic [2*NUM_PINS-1:0] pull_sel,
   output logic                  irq
);

   localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;

   if (DATA_W < 8) begin : g_bad_data
      $error("gpio_edge_ctrl: DATA_W must be at least 8");
   end
   if (GRP0_PINS < 1 || GRP1_PINS < 1) begin : g_bad_split
      $error("gpio_edge_ctrl: both interrupt groups need at least one pin");
   end
   if (GRP0_PINS > DATA_W || GRP1_PINS > DATA_W) begin : g_bad_grp
      $error("gpio_edge_ctrl: a group must fit one data word");
   end

   logic [OC_W-1:0]     octl_a [NUM_PINS];
   det_mode_e           mode_a [NUM_PINS];
   logic [NUM_PINS-1:0] lvl_v, evt_v;
   logic [GRP0_PINS-1:0] stat0, mask0;
   logic [GRP1_PINS-1:0] stat1, mask1;
   logic                 pend0, pend1;
   logic [DATA_W-1:0]    rd_c;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) cell_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .octl_we  (bus_we && bus_addr == OUT_BASE + ADDR_W'(i)),
         .octl_wd  (bus_wdata[OC_W-1:0]),
         .ictl_we  (bus_we && bus_addr == IN_BASE + ADDR_W'(i)),
         .mode_wd  (bus_wdata[2:1]),
         .pin_in   (pin_in[i]),
         .octl_q   (octl_a[i]),
         .mode_q   (mode_a[i]),
         .level_q  (lvl_v[i]),
         .edge_evt (evt_v[i]),
         .pad_oe   (pad_oe[i]),
         .pad_out  (pad_out[i]),
         .pull_en  (pull_en[i]),
         .pull_sel (pull_sel[2*i +: 2])
      );
   end

   gpio_irq_group #(.W(GRP0_PINS)) grp0_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_we (bus_we && bus_addr == STAT_BASE),
      .mask_we (bus_we && bus_addr == MASK_BASE),
      .wdata   (bus_wdata[GRP0_PINS-1:0]),
      .evt     (evt_v[GRP0_PINS-1:0]),
      .stat_q  (stat0),
      .mask_q  (mask0),
      .pend    (pend0)
   );

   gpio_irq_group #(.W(GRP1_PINS)) grp1_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_we (bus_we && bus_addr == STAT_BASE + ADDR_W'(1)),
      .mask_we (bus_we && bus_addr == MASK_BASE + ADDR_W'(1)),
      .wdata   (bus_wdata[GRP1_PINS-1:0]),
      .evt     (evt_v[NUM_PINS-1:GRP0_PINS]),
      .stat_q  (stat1),
      .mask_q  (mask1),
      .pend    (pend1)
   );

   if (GRP0_PINS < DATA_W && GRP1_PINS < DATA_W) begin : g_spare
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:OC_W];
   end

   always_comb begin
      rd_c = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (bus_addr == OUT_BASE + ADDR_W'(i)) rd_c = DATA_W'(octl_a[i]);
         if (bus_addr == IN_BASE + ADDR_W'(i))  rd_c = DATA_W'({mode_a[i], lvl_v[i]});
      end
      if (bus_addr == STAT_BASE)               rd_c = DATA_W'(stat0);
      if (bus_addr == STAT_BASE + ADDR_W'(1))  rd_c = DATA_W'(stat1);
      if (bus_addr == MASK_BASE)               rd_c = DATA_W'(mask0);
      if (bus_addr == MASK_BASE + ADDR_W'(1))  rd_c = DATA_W'(mask1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         irq       <= 1'b0;
      end else begin
         bus_rdata <= bus_re ? rd_c : '0;
         irq       <= pend0 | pend1;
      end
   end

   // R10
   irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(pend0 | pend1));

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;

   localparam int NP = 13;
   localparam logic [15:0] A_OUT  = 16'h4E44;
   localparam logic [15:0] A_IN   = 16'h4E51;
   localparam logic [15:0] A_STAT = 16'h4E0B;
   localparam logic [15:0] A_MASK = 16'h4E19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic          bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0]    bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pad_oe, pad_out, pull_en;
   logic [2*NP-1:0] pull_sel;
   logic          irq;

   int nchk = 0, nerr = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_edge_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pull_en(pull_en), .pull_sel(pull_sel),
      .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_oe(logic [5:0] c);
      return int'(c[5] & (c[4] | ~c[0]));
   endfunction
   function automatic int exp_out(logic [5:0] c);
      return int'(c[5] & c[4] & c[0]);
   endfunction
   function automatic int exp_hit(logic [1:0] m, logic o, logic n);
      case (m)
         2'd1: return int'(o & ~n);
         2'd2: return int'(~o & n);
         2'd3: return int'(o ^ n);
         default: return 0;
      endcase
   endfunction

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] d;
      int seed;
      seed = $urandom(32'd20240611);
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 irq", int'(irq), 0);
      chk("R1 pad_oe", int'(pad_oe), 0);
      chk("R1 pad_out", int'(pad_out), 0);
      chk("R1 pull_en", int'(pull_en), 0);
      bus_rd(A_MASK, d);              chk("R1 mask0", int'(d), 'h7F);
      bus_rd(A_MASK + 16'd1, d);      chk("R1 mask1", int'(d), 'h3F);
      bus_rd(A_STAT, d);              chk("R1 stat0", int'(d), 0);
      bus_rd(A_STAT + 16'd1, d);      chk("R1 stat1", int'(d), 0);
      bus_rd(A_OUT + 16'd12, d);      chk("R1 drive12", int'(d), 0);
      bus_rd(A_IN, d);                chk("R1 sense0", int'(d), 0);

      // R11 unmapped and spare bits
      bus_rd(16'h4E43, d);            chk("R11 below drive", int'(d), 0);
      bus_rd(16'h4E5E, d);            chk("R11 above sense", int'(d), 0);
      bus_rd(16'h4E0D, d);            chk("R11 after status", int'(d), 0);
      bus_wr(A_MASK + 16'd1, 8'hFF);
      bus_rd(A_MASK + 16'd1, d);      chk("R11 mask1 spare bits", int'(d), 'h3F);
      bus_wr(A_MASK, 8'hFF);
      bus_rd(A_MASK, d);              chk("R11 mask0 spare bit", int'(d), 'h7F);

      // R3 R4 directed drive cases on pin 0
      bus_wr(A_OUT, 8'h31);
      chk("R3 pp high oe", int'(pad_oe[0]), 1);   chk("R3 pp high out", int'(pad_out[0]), 1);
      bus_wr(A_OUT, 8'h30);
      chk("R3 pp low oe", int'(pad_oe[0]), 1);    chk("R3 pp low out", int'(pad_out[0]), 0);
      bus_wr(A_OUT, 8'h21);
      chk("R4 od release oe", int'(pad_oe[0]), 0); chk("R4 od release out", int'(pad_out[0]), 0);
      bus_wr(A_OUT, 8'h20);
      chk("R4 od low oe", int'(pad_oe[0]), 1);    chk("R4 od low out", int'(pad_out[0]), 0);
      bus_wr(A_OUT, 8'h11);
      chk("R3 input dir oe", int'(pad_oe[0]), 0); chk("R3 input dir out", int'(pad_out[0]), 0);

      // R2 R3 R4 R5 random drive settings
      for (int k = 0; k < 60; k++) begin
         int p;
         logic [5:0] v;
         p = int'($urandom % NP);
         v = 6'($urandom);
         bus_wr(A_OUT + 16'(p), {2'b11, v});
         chk(v[4] ? "R3 oe" : "R4 oe", int'(pad_oe[p]), exp_oe(v));
         chk(v[4] ? "R3 out" : "R4 out", int'(pad_out[p]), exp_out(v));
         chk("R5 pull_en", int'(pull_en[p]), int'(v[3]));
         chk("R5 pull_sel", int'(pull_sel[2*p +: 2]), int'(v[2:1]));
         bus_rd(A_OUT + 16'(p), d);
         chk("R2 readback", int'(d), int'(v));
      end

      // R6 sense register
      pin_in[5] = 1'b1; idle(3);
      bus_wr(A_IN + 16'd5, 8'h04);
      bus_rd(A_IN + 16'd5, d);        chk("R6 level high mode rise", int'(d), 'h05);
      pin_in[5] = 1'b0; idle(3);
      bus_wr(A_IN + 16'd5, 8'h01);
      bus_rd(A_IN + 16'd5, d);        chk("R6 bit0 write ignored", int'(d), 'h00);

      // R7 R8 random transitions and modes
      for (int k = 0; k < 40; k++) begin
         int p, ex;
         logic [1:0] m;
         logic o, n;
         p = int'($urandom % NP);
         m = 2'($urandom);
         o = pin_in[p];
         n = 1'($urandom);
         bus_wr(A_IN + 16'(p), {5'b0, m, 1'b0});
         bus_wr(A_STAT, 8'hFF);
         bus_wr(A_STAT + 16'd1, 8'hFF);
         pin_in[p] = n;
         idle(4);
         ex = exp_hit(m, o, n);
         if (p < 7) begin
            bus_rd(A_STAT, d);         chk("R7 group0 event", int'(d), ex << p);
            bus_rd(A_STAT + 16'd1, d); chk("R8 group1 untouched", int'(d), 0);
         end else begin
            bus_rd(A_STAT + 16'd1, d); chk("R7 group1 event", int'(d), ex << (p - 7));
            bus_rd(A_STAT, d);         chk("R8 group0 untouched", int'(d), 0);
         end
      end

      // R10 mask gating on pin 9 (group1 bit 2)
      bus_wr(A_IN + 16'd9, 8'h06);
      bus_wr(A_STAT, 8'hFF);
      bus_wr(A_STAT + 16'd1, 8'hFF);
      idle(2);
      pin_in[9] = ~pin_in[9];
      idle(4);
      chk("R10 masked irq low", int'(irq), 0);
      bus_rd(A_STAT + 16'd1, d);      chk("R10 pending while masked", int'(d), 'h04);
      bus_wr(A_MASK + 16'd1, 8'h3B);
      idle(1);
      chk("R10 unmasked irq high", int'(irq), 1);
      bus_wr(A_STAT + 16'd1, 8'h00);
      bus_rd(A_STAT + 16'd1, d);      chk("R8 write zero keeps", int'(d), 'h04);
      chk("R10 irq held", int'(irq), 1);
      bus_wr(A_STAT + 16'd1, 8'h04);
      idle(1);
      chk("R10 irq drops", int'(irq), 0);
      bus_rd(A_STAT + 16'd1, d);      chk("R8 write one clears", int'(d), 0);

      // R9 clear and event in the same cycle
      pin_in[9] = ~pin_in[9];
      idle(4);
      bus_rd(A_STAT + 16'd1, d);      chk("R9 preset pending", int'(d), 'h04);
      @(negedge clk);
      pin_in[9] = ~pin_in[9];
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_addr = A_STAT + 16'd1; bus_wdata = 8'h04; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      bus_rd(A_STAT + 16'd1, d);      chk("R9 set wins over clear", int'(d), 'h04);
      chk("R10 irq after collision", int'(irq), 1);
      bus_wr(A_STAT + 16'd1, 8'h04);
      bus_rd(A_STAT + 16'd1, d);      chk("R8 clear after collision", int'(d), 0);

      done = 1;
      finish_run();
   end

endmodule